// File: doc/BRIEF.md
# Register-Pair Bit-Field Extractor

This block pulls a bit field out of a 64-bit value formed from two 32-bit source words and returns it as a 32-bit result. The field is either zero-extended or sign-extended. The caller picks the field in one of two ways. In the first, an immediate offset and an immediate width-minus-one are given directly. In the second, a 32-bit descriptor word holds a 6-bit offset and a 6-bit width, and those two fields can sit at one of several placements inside the word.

The extraction itself is combinational. The result is captured in a register together with a single-cycle valid flag, so a request presented in one cycle appears at the output in the next. The block fits beside an execute stage that has already read both pair registers and the descriptor from the register file.

Top module: `bfx_pair_extract`

## Requirements
- R1: While reset is high, and after reset before any request, out_valid is 0 and out_data is 0.
- R2: A request with in_valid high at a clock edge gives out_valid high, with its result on out_data, for exactly the following cycle. A cycle without in_valid gives out_valid low in the next cycle.
- R3: The source is the 64-bit value {src_hi, src_lo}, so src_hi occupies bits 63:32.
- R4: The offset is 6 bits (0..63) and shifts the pair right. Positions above bit 63 read as zero.
- R5: A descriptor width field above 32 (33..63) acts as a width of 32.
- R6: An effective width of 0 gives a result of 0 in both unsigned and signed modes.
- R7: When sign_en is 0, result bits at and above the width are 0.
- R8: When sign_en is 1 and the width is 1..31, field bit (width-1) is copied into every higher result bit.
- R9: A width of 32 returns the 32 shifted bits unchanged in both modes.
- R10: When use_desc is 1, place selects where the fields are read. place=0: width desc[21:16], offset desc[5:0]. place=1: width desc[13:8], offset desc[5:0]. place=2: width desc[29:24], offset desc[21:16]. place=3 reads the same fields as place=0. All other descriptor bits are ignored.
- R11: When use_desc is 0, the offset is imm_off and the width is imm_wm1+1 (1..32). The descriptor is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_lo | input | 32 | Lower word of the pair (bits 31:0) |
| src_hi | input | 32 | Upper word of the pair (bits 63:32) |
| desc | input | 32 | Packed offset/width descriptor |
| imm_off | input | 6 | Immediate offset |
| imm_wm1 | input | 5 | Immediate width minus one |
| use_desc | input | 1 | 1: take fields from desc, 0: from immediates |
| place | input | 2 | Descriptor field placement select |
| sign_en | input | 1 | 1: sign-extend, 0: zero-extend |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 32 | Extracted, extended field |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 6-bit offset and a 6-bit width field. With these values every offset from 0 to 63 can be reached, so fields that run past bit 63 can be tested. The descriptor width codes 33 to 63 can also be reached, so the clamp is tested from both its low and high ends. Requests are sent back to back and with gaps. Descriptors carry all-ones filler in every bit they do not use, so any wrongly read bit changes the result.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int DW = 32;
  localparam int OW = 6;
  localparam int WW = 6;

  // descriptor field positions (lsb of each field)
  localparam int PA_WID = 16;
  localparam int PA_OFF = 0;
  localparam int PB_WID = 8;
  localparam int PB_OFF = 0;
  localparam int PC_WID = 24;
  localparam int PC_OFF = 16;

  typedef enum logic [1:0] {
    PLACE_A   = 2'd0,
    PLACE_B   = 2'd1,
    PLACE_C   = 2'd2,
    PLACE_ALT = 2'd3
  } place_e;
endpackage

// File: rtl/bfx_locate.sv
module bfx_locate
  import bfx_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int OFF_W  = OW,
  parameter int WID_W  = WW
) (
  input  logic [DATA_W-1:0] desc,
  input  logic [OFF_W-1:0]  imm_off,
  input  logic [WID_W-2:0]  imm_wm1,
  input  logic              use_desc,
  input  logic [1:0]        place,
  output logic [OFF_W-1:0]  off,
  output logic [WID_W-1:0]  wid
);
  localparam logic [WID_W-1:0] WMAX = WID_W'(DATA_W);

  logic [WID_W-1:0] raw_w;
  logic [OFF_W-1:0] raw_o;
  logic [WID_W-1:0] clamped_w;
  logic [WID_W-1:0] imm_w;

  always_comb begin
    unique case (place_e'(place))
      PLACE_B: begin
        raw_w = desc[PB_WID +: WID_W];
        raw_o = desc[PB_OFF +: OFF_W];
      end
      PLACE_C: begin
        raw_w = desc[PC_WID +: WID_W];
        raw_o = desc[PC_OFF +: OFF_W];
      end
      default: begin
        raw_w = desc[PA_WID +: WID_W];
        raw_o = desc[PA_OFF +: OFF_W];
      end
    endcase
  end

  assign clamped_w = (raw_w > WMAX) ? WMAX : raw_w;
  assign imm_w     = {1'b0, imm_wm1} + WID_W'(1);

  assign off = use_desc ? raw_o : imm_off;
  assign wid = use_desc ? clamped_w : imm_w;

  logic desc_unused;
  assign desc_unused = ^{desc[7:6], desc[15:14], desc[23:22], desc[31:30]};
endmodule

// File: rtl/bfx_core.sv
module bfx_core
  import bfx_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int OFF_W  = OW,
  parameter int WID_W  = WW
) (
  input  logic [DATA_W-1:0] src_lo,
  input  logic [DATA_W-1:0] src_hi,
  input  logic [OFF_W-1:0]  off,
  input  logic [WID_W-1:0]  wid,
  input  logic              sign_en,
  output logic [DATA_W-1:0] res
);
  localparam int PAIR_W = 2 * DATA_W;
  localparam int IDX_W  = $clog2(DATA_W);

  logic [PAIR_W-1:0] pair;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] keep;
  logic [IDX_W-1:0]  top_idx;
  logic              fill;

  assign pair    = {src_hi, src_lo};
  assign shifted = DATA_W'(pair >> off);

  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    assign keep[i] = (WID_W'(i) < wid);
  end

  assign top_idx = IDX_W'(wid - WID_W'(1));
  assign fill    = sign_en && (wid != '0) && shifted[top_idx];
  assign res     = (shifted & keep) | ({DATA_W{fill}} & ~keep);
endmodule

// File: rtl/bfx_pair_extract.sv
module bfx_pair_extract
  import bfx_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int OFF_W  = OW,
  parameter int WID_W  = WW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_lo,
  input  logic [DATA_W-1:0] src_hi,
  input  logic [DATA_W-1:0] desc,
  input  logic [OFF_W-1:0]  imm_off,
  input  logic [WID_W-2:0]  imm_wm1,
  input  logic              use_desc,
  input  logic [1:0]        place,
  input  logic              sign_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [OFF_W-1:0]  off;
  logic [WID_W-1:0]  wid;
  logic [DATA_W-1:0] res;

  bfx_locate #(.DATA_W(DATA_W), .OFF_W(OFF_W), .WID_W(WID_W)) u_locate (
    .desc     (desc),
    .imm_off  (imm_off),
    .imm_wm1  (imm_wm1),
    .use_desc (use_desc),
    .place    (place),
    .off      (off),
    .wid      (wid)
  );

  bfx_core #(.DATA_W(DATA_W), .OFF_W(OFF_W), .WID_W(WID_W)) u_core (
    .src_lo  (src_lo),
    .src_hi  (src_hi),
    .off     (off),
    .wid     (wid),
    .sign_en (sign_en),
    .res     (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= res;
    end
  end

  localparam logic [WID_W-1:0] FULL_W = WID_W'(DATA_W);

  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r6_zero_width: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wid == '0) |=> (out_data == '0));
  a_r7_unsigned_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sign_en && wid < FULL_W) |=> ((out_data >> $past(wid)) == '0));
  a_r8_signed_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sign_en && wid != '0 && wid < FULL_W) |=>
      (((out_data >> ($past(wid) - WID_W'(1))) == '0) ||
       ((~out_data >> ($past(wid) - WID_W'(1))) == '0)));
endmodule

// File: tb/sim_bfx_pair_extract.sv
`timescale 1ns/1ps
module sim_bfx_pair_extract;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] src_lo = '0, src_hi = '0, desc = '0;
  logic [5:0]  imm_off = '0;
  logic [4:0]  imm_wm1 = '0;
  logic        use_desc = 1'b0, sign_en = 1'b0;
  logic [1:0]  place = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  bfx_pair_extract u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_lo(src_lo), .src_hi(src_hi),
    .desc(desc), .imm_off(imm_off), .imm_wm1(imm_wm1), .use_desc(use_desc),
    .place(place), .sign_en(sign_en), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] model(logic [31:0] hi, logic [31:0] lo,
                                        int ofs, int w, bit sgn);
    logic [63:0] p;
    logic [31:0] r;
    p = {hi, lo};
    r = '0;
    for (int i = 0; i < w; i++) r[i] = (ofs + i < 64) ? p[ofs + i] : 1'b0;
    if (sgn && w > 0 && w < 32)
      for (int i = w; i < 32; i++) r[i] = r[w - 1];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_imm(logic [31:0] hi, logic [31:0] lo, int ofs, int wm1,
                         bit sgn, string tag);
    @(negedge clk);
    in_valid = 1'b1; src_hi = hi; src_lo = lo; use_desc = 1'b0;
    desc = 32'hFFFF_FFFF; place = 2'd2;
    imm_off = 6'(ofs); imm_wm1 = 5'(wm1); sign_en = sgn;
    exp_q.push_back(model(hi, lo, ofs, wm1 + 1, sgn));
    tag_q.push_back(tag);
  endtask

  task automatic run_desc(logic [31:0] hi, logic [31:0] lo, int plc, int ofs,
                          int wf, bit sgn, string tag);
    logic [31:0] d;
    d = 32'hFFFF_FFFF;
    case (plc)
      1: begin d[13:8] = 6'(wf); d[5:0] = 6'(ofs); end
      2: begin d[29:24] = 6'(wf); d[21:16] = 6'(ofs); end
      default: begin d[21:16] = 6'(wf); d[5:0] = 6'(ofs); end
    endcase
    @(negedge clk);
    in_valid = 1'b1; src_hi = hi; src_lo = lo; use_desc = 1'b1;
    desc = d; place = 2'(plc); sign_en = sgn;
    imm_off = 6'd13; imm_wm1 = 5'd2;
    exp_q.push_back(model(hi, lo, ofs, (wf > 32) ? 32 : wf, sgn));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        tests++;
        fails++;
        $display("FAIL R2: unexpected out_valid, actual 1 expected 0");
      end else begin
        check(tag_q.pop_front(), out_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset data", out_data, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 idle valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 idle data after reset", out_data, 32'd0);

    // R3 pair ordering, R11 immediate form (descriptor filled with ones)
    run_imm(32'h89AB_CDEF, 32'h1234_5678, 0, 31, 1'b0, "R3 R11 low word");
    run_imm(32'h89AB_CDEF, 32'h1234_5678, 32, 31, 1'b0, "R3 R11 high word");
    run_imm(32'h89AB_CDEF, 32'h1234_5678, 16, 31, 1'b0, "R3 straddle");
    run_imm(32'h89AB_CDEF, 32'h1234_5678, 20, 7, 1'b0, "R11 imm width 8");
    // R4 offsets reaching past bit 63
    run_imm(32'h8000_0000, 32'h0, 63, 7, 1'b0, "R4 offset 63 unsigned");
    run_imm(32'h8000_0000, 32'h0, 63, 7, 1'b1, "R4 offset 63 signed");
    run_imm(32'hF0F0_F0F0, 32'h0, 40, 31, 1'b0, "R4 offset 40 w32");
    idle(2);
    // R7 / R8 extension
    run_imm(32'h0, 32'hFFFF_FFFF, 4, 4, 1'b0, "R7 unsigned w5");
    run_imm(32'h0, 32'h0000_00F0, 4, 4, 1'b1, "R8 signed positive w5");
    run_imm(32'h0, 32'h0000_01F0, 4, 4, 1'b1, "R8 signed negative w5");
    run_imm(32'h0000_0001, 32'h8000_0000, 31, 1, 1'b1, "R8 signed across words");
    // R9 full width
    run_imm(32'h0, 32'h8765_4321, 0, 31, 1'b1, "R9 w32 signed");
    run_imm(32'hDEAD_BEEF, 32'h0, 32, 31, 1'b0, "R9 w32 unsigned");
    idle(1);
    // R10 placements
    run_desc(32'h89AB_CDEF, 32'h1234_5678, 0, 12, 10, 1'b0, "R10 place 0");
    run_desc(32'h89AB_CDEF, 32'h1234_5678, 1, 36, 9, 1'b1, "R10 place 1");
    run_desc(32'h89AB_CDEF, 32'h1234_5678, 2, 28, 13, 1'b1, "R10 place 2");
    run_desc(32'h89AB_CDEF, 32'h1234_5678, 3, 5, 20, 1'b0, "R10 place 3");
    // R5 clamp
    run_desc(32'hCAFE_F00D, 32'h0BAD_BEEF, 0, 8, 33, 1'b1, "R5 width 33");
    run_desc(32'hCAFE_F00D, 32'h0BAD_BEEF, 1, 44, 63, 1'b0, "R5 width 63");
    run_desc(32'hCAFE_F00D, 32'h0BAD_BEEF, 2, 3, 40, 1'b1, "R5 width 40");
    run_desc(32'hCAFE_F00D, 32'h0BAD_BEEF, 0, 0, 32, 1'b0, "R5 width 32");
    // R6 zero width
    run_desc(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 7, 0, 1'b0, "R6 zero unsigned");
    run_desc(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 7, 0, 1'b1, "R6 zero signed");
    idle(3);
    check("R2 idle after burst", {31'd0, out_valid}, 32'd0);
    check("R2 all results seen", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule